// File: doc/BRIEF.md
# Caption Data Clock Recovery

This block recovers the bit clock of the closed-caption data line in the vertical blanking interval. It then uses that clock to resample the one-bit sliced data and recover the caption bytes. It runs from a 12 MHz system clock, where one data bit lasts about 24 clocks (the bit rate is 32 times the line rate). Three inputs drive it: the sliced data bit, a gate that is high while the caption line is in progress, and a flag that reports a change of the incoming video. Lines from both fields pass through the same logic.

While it is unlocked, the block takes the first rising transition inside a gated line as a reference. It then measures where each of the next four rising transitions of the run-in burst falls relative to a bit-period phase counter, averages those four offsets, and moves the counter by the average. From that point the lock is held. Later lines reuse the same phase without looking at their run-in again, until the video-change flag drops the lock. Once locked, the block samples one bit per period at mid-bit and hunts for the start pattern. It then captures two bytes. Each byte is seven data bits followed by an odd-parity bit, and each is delivered with a one-cycle strobe, a byte index and a parity-error flag.

Top module: `cc_caption_cdr`

## Requirements
- R1: After reset, locked, byte_valid and parity_error are 0 and byte_data is 0.
- R2: While unlocked, the first rising edge of sliced with line_gate high is the phase reference, and locked rises on the fourth rising edge after it in the same line. A line whose run-in has fewer edges leaves locked at 0, and dropping line_gate discards a partial acquisition.
- R3: The bit phase is set so that a data transition falls at the reference plus the floor of the mean of the four signed edge offsets, each offset taken in the range -BIT_CLKS/2 to BIT_CLKS/2-1. Data bits are sampled half a bit period after that phase, once per bit period.
- R4: Once set, locked stays high across lines until video_change, and rising edges in later lines do not move the phase. A line with no run-in is still decoded on the held phase.
- R5: video_change clears locked on the next clock, and the next run-in reacquires phase at its own alignment.
- R6: After lock, the sampled bit sequence 0,0,1 (oldest first) marks the start. The next 8 sampled bits form a byte whose first bit is byte_data bit 0, continuing LSB first through bit 6, and whose eighth bit is the parity bit.
- R7: Exactly two bytes are delivered per line. byte_valid is a one-cycle pulse that follows the sampling tick of the byte's last bit, and byte_index is 0 for the first byte and 1 for the second.
- R8: parity_error is 1 with a byte exactly when the count of ones over its seven data bits and its parity bit is even.
- R9: If the start pattern has not completed within START_WINDOW (16) sampled bits of the line, the line is discarded, and no strobe appears for it even if the pattern comes later.
- R10: A fall of line_gate abandons a line in progress without a strobe, and byte_valid only follows a cycle with line_gate high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| sliced | input | 1 | Sliced data bit, synchronous to clk |
| line_gate | input | 1 | High for the duration of the caption line |
| video_change | input | 1 | One-cycle pulse that reports a change of the video; drops the lock |
| locked | output | 1 | Bit phase is acquired and held |
| byte_data | output | 7 | Seven data bits of the last captured byte |
| byte_valid | output | 1 | One-cycle strobe for byte_data |
| parity_error | output | 1 | Odd-parity check failed for the strobed byte |
| byte_index | output | 1 | Position of the strobed byte within its line |

## Verification
The properties take for granted that video_change arrives only while line_gate is low, so that the lock cannot fall between a sampling tick and its strobe. They also assume that sliced is already synchronous to clk and that the bit period spans many clocks, which makes ticks and strobes separate single-cycle events. The bench drives every input at the falling clock edge and pulses video_change only between lines. It keeps run-in jitter, reference displacement and data shift inside half a bit period, so that a correct average always samples inside the intended bit.

// File: rtl/cc_cdr_pkg.sv
package cc_cdr_pkg;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_HUNT,
    FR_DATA,
    FR_DONE
  } fr_state_t;

  localparam int START_LEN = 3;
  localparam logic [START_LEN-1:0] START_PATTERN = 3'b001;

endpackage

// File: rtl/cc_cdr_edge.sv
module cc_cdr_edge (
  input  logic clk,
  input  logic rst,
  input  logic sliced,
  output logic rise
);

  logic sl_q;

  always_ff @(posedge clk) begin
    if (rst) sl_q <= 1'b0;
    else     sl_q <= sliced;
  end

  assign rise = sliced & ~sl_q;

endmodule

// File: rtl/cc_cdr_phase.sv
module cc_cdr_phase #(
  parameter int BIT_CLKS = 24,
  parameter int AVG_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic line_gate,
  input  logic video_change,
  output logic locked,
  output logic mid_tick
);

  localparam int CW    = $clog2(BIT_CLKS);
  localparam int HALF  = BIT_CLKS / 2;
  localparam int AVG_N = 1 << AVG_LOG2;
  localparam int EW    = $clog2(AVG_N + 1);
  localparam int SW    = CW + AVG_LOG2 + 3;
  localparam logic signed [SW-1:0] PERIOD_S = SW'(BIT_CLKS);
  localparam logic signed [SW-1:0] ONE_S    = SW'(1);

  logic [CW-1:0] cnt, cnt_inc;
  logic [EW-1:0] ecnt;
  logic          lock_q;
  logic signed [SW-1:0] cnt_s, err, sum_q, sum_n, avg, adj;

  assign cnt_s   = $signed({{(SW-CW){1'b0}}, cnt});
  assign cnt_inc = (cnt == CW'(BIT_CLKS - 1)) ? '0 : cnt + CW'(1);

  // Signed offset of the current edge from the nominal transition phase,
  // folded into one bit period, then the running average and the new phase.
  always_comb begin
    err   = (cnt < CW'(HALF)) ? cnt_s : cnt_s - PERIOD_S;
    sum_n = sum_q + err;
    avg   = sum_n >>> AVG_LOG2;
    adj   = cnt_s + ONE_S - avg;
    if (adj >= PERIOD_S)
      adj = adj - PERIOD_S;
    else if (adj < 0)
      adj = adj + PERIOD_S;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      ecnt   <= '0;
      sum_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt <= cnt_inc;
      if (video_change) begin
        lock_q <= 1'b0;
        ecnt   <= '0;
        sum_q  <= '0;
      end else if (!lock_q) begin
        if (!line_gate) begin
          ecnt  <= '0;
          sum_q <= '0;
        end else if (rise) begin
          if (ecnt == '0) begin
            cnt   <= CW'(1);
            ecnt  <= EW'(1);
            sum_q <= '0;
          end else if (ecnt == EW'(AVG_N)) begin
            cnt    <= CW'(adj);
            lock_q <= 1'b1;
            ecnt   <= '0;
            sum_q  <= '0;
          end else begin
            sum_q <= sum_n;
            ecnt  <= ecnt + EW'(1);
          end
        end
      end
    end
  end

  assign locked   = lock_q;
  assign mid_tick = lock_q & (cnt == CW'(HALF));

endmodule

// File: rtl/cc_cdr_framer.sv
module cc_cdr_framer
  import cc_cdr_pkg::*;
#(
  parameter int DATA_BITS      = 7,
  parameter int BYTES_PER_LINE = 2,
  parameter int START_WINDOW   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_in,
  input  logic                 tick,
  input  logic                 line_gate,
  output logic [DATA_BITS-1:0] byte_data,
  output logic                 byte_valid,
  output logic                 parity_error,
  output logic [((BYTES_PER_LINE > 1) ? $clog2(BYTES_PER_LINE) : 1)-1:0] byte_index
);

  localparam int FRAME_BITS = DATA_BITS + 1;
  localparam int BW = $clog2(FRAME_BITS);
  localparam int WW = $clog2(START_WINDOW + 1);
  localparam int IW = (BYTES_PER_LINE > 1) ? $clog2(BYTES_PER_LINE) : 1;

  fr_state_t              state;
  logic [START_LEN-1:0]   sh, sh_n;
  logic [WW-1:0]          win;
  logic [BW-1:0]          bitcnt;
  logic [IW-1:0]          bytecnt;
  logic [FRAME_BITS-1:0]  frame_q, frame_n;

  assign sh_n    = {sh[START_LEN-2:0], bit_in};
  assign frame_n = {bit_in, frame_q[FRAME_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= FR_IDLE;
      sh           <= '1;
      win          <= '0;
      bitcnt       <= '0;
      bytecnt      <= '0;
      frame_q      <= '0;
      byte_data    <= '0;
      byte_valid   <= 1'b0;
      parity_error <= 1'b0;
      byte_index   <= '0;
    end else begin
      byte_valid   <= 1'b0;
      parity_error <= 1'b0;
      if (!line_gate) begin
        state <= FR_IDLE;
      end else begin
        case (state)
          FR_IDLE: begin
            state   <= FR_HUNT;
            sh      <= '1;
            win     <= '0;
            bitcnt  <= '0;
            bytecnt <= '0;
          end
          FR_HUNT: begin
            if (tick) begin
              sh  <= sh_n;
              win <= win + WW'(1);
              if (sh_n == START_PATTERN) begin
                state  <= FR_DATA;
                bitcnt <= '0;
              end else if (win == WW'(START_WINDOW - 1)) begin
                state <= FR_DONE;
              end
            end
          end
          FR_DATA: begin
            if (tick) begin
              frame_q <= frame_n;
              if (bitcnt == BW'(FRAME_BITS - 1)) begin
                byte_data    <= frame_n[DATA_BITS-1:0];
                parity_error <= ~(^frame_n);
                byte_valid   <= 1'b1;
                byte_index   <= bytecnt;
                bitcnt       <= '0;
                if (bytecnt == IW'(BYTES_PER_LINE - 1))
                  state <= FR_DONE;
                else
                  bytecnt <= bytecnt + IW'(1);
              end else begin
                bitcnt <= bitcnt + BW'(1);
              end
            end
          end
          default: state <= FR_DONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cc_caption_cdr.sv
module cc_caption_cdr #(
  parameter int BIT_CLKS       = 24,
  parameter int AVG_LOG2       = 2,
  parameter int DATA_BITS      = 7,
  parameter int BYTES_PER_LINE = 2,
  parameter int START_WINDOW   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sliced,
  input  logic                 line_gate,
  input  logic                 video_change,
  output logic                 locked,
  output logic [DATA_BITS-1:0] byte_data,
  output logic                 byte_valid,
  output logic                 parity_error,
  output logic [((BYTES_PER_LINE > 1) ? $clog2(BYTES_PER_LINE) : 1)-1:0] byte_index
);

  logic rise;
  logic mid_tick;

  cc_cdr_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sliced (sliced),
    .rise   (rise)
  );

  cc_cdr_phase #(
    .BIT_CLKS (BIT_CLKS),
    .AVG_LOG2 (AVG_LOG2)
  ) u_phase (
    .clk          (clk),
    .rst          (rst),
    .rise         (rise),
    .line_gate    (line_gate),
    .video_change (video_change),
    .locked       (locked),
    .mid_tick     (mid_tick)
  );

  cc_cdr_framer #(
    .DATA_BITS      (DATA_BITS),
    .BYTES_PER_LINE (BYTES_PER_LINE),
    .START_WINDOW   (START_WINDOW)
  ) u_framer (
    .clk          (clk),
    .rst          (rst),
    .bit_in       (sliced),
    .tick         (mid_tick),
    .line_gate    (line_gate),
    .byte_data    (byte_data),
    .byte_valid   (byte_valid),
    .parity_error (parity_error),
    .byte_index   (byte_index)
  );

endmodule

// File: rtl/cc_caption_cdr_chk.sv
module cc_caption_cdr_chk (
  input logic clk,
  input logic rst,
  input logic line_gate,
  input logic video_change,
  input logic locked,
  input logic byte_valid,
  input logic mid_tick
);

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !video_change) |=> locked);

  // R5
  lock_clear_chk: assert property (@(posedge clk) disable iff (rst)
    video_change |=> !locked);

  // R2
  lock_in_line_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(line_gate));

  // R3
  one_tick_per_bit_chk: assert property (@(posedge clk) disable iff (rst)
    mid_tick |=> !mid_tick);

  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  // R6
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(mid_tick));

  // R10
  strobe_in_line_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(line_gate));

endmodule

bind cc_caption_cdr cc_caption_cdr_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .line_gate    (line_gate),
  .video_change (video_change),
  .locked       (locked),
  .byte_valid   (byte_valid),
  .mid_tick     (mid_tick)
);

// File: tb/tb_cc_caption_cdr.sv
module tb_cc_caption_cdr;

  localparam int B = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sliced = 1'b0;
  logic       line_gate = 1'b0;
  logic       video_change = 1'b0;
  logic       locked;
  logic [6:0] byte_data;
  logic       byte_valid;
  logic       parity_error;
  logic [0:0] byte_index;

  cc_caption_cdr dut (
    .clk          (clk),
    .rst          (rst),
    .sliced       (sliced),
    .line_gate    (line_gate),
    .video_change (video_change),
    .locked       (locked),
    .byte_data    (byte_data),
    .byte_valid   (byte_valid),
    .parity_error (parity_error),
    .byte_index   (byte_index)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8:0] rx [0:63];
  int nrx = 0;
  always @(negedge clk) begin
    if (!rst && byte_valid) begin
      rx[nrx % 64] <= {byte_index, parity_error, byte_data};
      nrx <= nrx + 1;
    end
  end

  // line description
  int lead, nrun, rsh, dsh;
  int jit [0:15];
  bit has_data;
  int frame [0:18];
  int base, grid0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int dstart();
    return lead + 2 * nrun * B + dsh;
  endfunction

  function automatic int level(input int t);
    int off, g, d0;
    for (int k = 0; k < nrun; k++) begin
      off = (k == 0) ? rsh : jit[k];
      g = lead + 2 * k * B;
      if (t >= g + off && t < g + B) return 1;
    end
    if (has_data) begin
      d0 = dstart();
      if (t >= d0 && t < d0 + 19 * B) return frame[(t - d0) / B];
    end
    return 0;
  endfunction

  task automatic set_frame(input int b1, input int f1, input int b2, input int f2);
    frame[0] = 0; frame[1] = 0; frame[2] = 1;
    for (int i = 0; i < 7; i++) begin
      frame[3 + i]  = (b1 >> i) & 1;
      frame[11 + i] = (b2 >> i) & 1;
    end
    frame[10] = (~(^b1[6:0]) ^ f1[0]) & 1;
    frame[18] = (~(^b2[6:0]) ^ f2[0]) & 1;
  endtask

  task automatic run_line(input int len_ovr);
    int len, start, s, a;
    len = (len_ovr > 0) ? len_ovr : dstart() + 21 * B;
    base = nrx;
    start = cyc;
    if (nrun >= 5 && !locked) begin
      s = 0;
      for (int k = 1; k <= 4; k++) s += jit[k] - rsh;
      a = (s >= 0) ? s / 4 : -((-s + 3) / 4);
      grid0 = start + lead + rsh + a;
    end
    for (int t = 0; t < len; t++) begin
      line_gate = 1'b1;
      sliced = level(t)[0];
      @(negedge clk);
    end
    sliced = 1'b0;
    line_gate = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic align_grid();
    while (((cyc + lead - grid0) % B) != 0) @(negedge clk);
  endtask

  task automatic pulse_change();
    video_change = 1'b1;
    @(negedge clk);
    video_change = 1'b0;
  endtask

  task automatic check_bytes(input string req, input int b1, input int p1, input int b2, input int p2);
    int n;
    logic [8:0] e;
    n = nrx - base;
    chk("R7", {req, " byte count"}, n, 2);
    if (n >= 2) begin
      e = rx[base % 64];
      chk(req, "first byte data", int'(e[6:0]), b1);
      chk("R7", "first byte index", int'(e[8]), 0);
      chk("R8", "first byte parity flag", int'(e[7]), p1);
      e = rx[(base + 1) % 64];
      chk(req, "second byte data", int'(e[6:0]), b2);
      chk("R7", "second byte index", int'(e[8]), 1);
      chk("R8", "second byte parity flag", int'(e[7]), p2);
    end
  endtask

  task automatic clear_jit();
    for (int k = 0; k < 16; k++) jit[k] = 0;
  endtask

  initial begin
    int b1, b2, f1, f2;
    clear_jit();
    rsh = 0; dsh = 0; lead = 2 * B; nrun = 7; has_data = 1'b1;
    set_frame(0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "locked after reset", int'(locked), 0);
    chk("R1", "byte_valid after reset", int'(byte_valid), 0);
    chk("R1", "parity_error after reset", int'(parity_error), 0);
    chk("R1", "byte_data after reset", int'(byte_data), 0);
    repeat (10) @(negedge clk);

    // R2 four run-in cycles are too few to lock
    nrun = 4; has_data = 1'b0;
    run_line(0);
    chk("R2", "locked after short run-in", int'(locked), 0);
    chk("R2", "strobes after short run-in", nrx - base, 0);

    // R3 R6 R8 sweep over line phase, jitter, data shift and byte values
    for (int ph = 0; ph < B; ph++) begin
      pulse_change();
      chk("R5", "locked after video change", int'(locked), 0);
      lead = 2 * B + ph; nrun = 7; rsh = 0; has_data = 1'b1;
      for (int k = 1; k < 7; k++) jit[k] = ((ph + k) % 5) - 2;
      dsh = (ph % 7) - 3;
      b1 = (ph * 37 + 5) & 127;
      b2 = (ph * 11 + 77) & 127;
      f1 = (ph % 4 == 1) ? 1 : 0;
      f2 = (ph % 4 == 3) ? 1 : 0;
      set_frame(b1, f1, b2, f2);
      run_line(0);
      chk("R2", "locked after full run-in", int'(locked), 1);
      check_bytes("R6", b1, f1, b2, f2);
      repeat (ph) @(negedge clk);
    end

    // R3 displaced reference edge corrected by the averaged offsets
    pulse_change();
    clear_jit();
    lead = 2 * B; nrun = 7; rsh = -10; dsh = 8; has_data = 1'b1;
    set_frame(7'h55, 0, 7'h2A, 0);
    run_line(0);
    check_bytes("R3", 7'h55, 0, 7'h2A, 0);

    // R4 held lock decodes a line with no run-in
    rsh = 0; dsh = 0; nrun = 0; lead = 2 * B;
    set_frame(7'h13, 0, 7'h6C, 1);
    align_grid();
    run_line(0);
    chk("R4", "locked held across lines", int'(locked), 1);
    check_bytes("R4", 7'h13, 0, 7'h6C, 1);

    // R9 start pattern after the window is ignored
    nrun = 16; lead = B; has_data = 1'b1;
    set_frame(7'h41, 0, 7'h22, 0);
    align_grid();
    run_line(0);
    chk("R9", "strobes on discarded line", nrx - base, 0);

    // R10 gate falls in the middle of the first byte
    nrun = 0; lead = 2 * B;
    set_frame(7'h7F, 0, 7'h01, 0);
    align_grid();
    run_line(dstart() + 8 * B);
    chk("R10", "strobes on aborted line", nrx - base, 0);
    align_grid();
    run_line(0);
    check_bytes("R10", 7'h7F, 0, 7'h01, 0);

    // R5 video change then reacquire at a new alignment
    pulse_change();
    chk("R5", "locked one cycle after video change", int'(locked), 0);
    repeat (7) @(negedge clk);
    lead = 2 * B + 11; nrun = 7; rsh = 0; dsh = 0;
    set_frame(7'h3C, 1, 7'h5A, 0);
    run_line(0);
    chk("R5", "locked after reacquire", int'(locked), 1);
    check_bytes("R5", 7'h3C, 1, 7'h5A, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule